// File: doc/BRIEF.md
# Multi-Device Tunable-Capacitor Serial Programmer

This block is a serial master that writes one 8-bit control word into each of several tunable-capacitor receivers over a three-wire bus. The host places one word per device on a wide input, picks a bus-sharing topology, and pulses `start`. The block then produces the serial clock, enable and data waveforms. Every interval on those waveforms is counted in system clock cycles and set by a parameter.

Two topologies are supported. In the per-device-enable topology (`mode_sel` = 0), all receivers share the clock and one data line, and each receiver has its own enable. The words go out one after another, so each receiver takes its new setting at the falling edge of its own enable. In the common-enable topology (`mode_sel` = 1), all receivers share one enable and each receiver has its own data line. All words shift out together, and every receiver updates at the same enable falling edge. A receiver keeps the last eight bits it saw before its enable falls.

Top module: `tsm_master`

## Requirements
- R1: During reset and whenever `busy` is low, `sclk`, `sdat`, `sen_dev`, `sen_all` and `sdat_lane` are all low. After reset, `busy` and `done` are low.
- R2: `sclk` stays high for at least CLK_HIGH_CYC cycles each time. Between two rising edges of one word, `sclk` stays low for at least CLK_LOW_CYC cycles.
- R3: Each enable window carries exactly 8 rising edges of `sclk`. The word is sent most significant bit first. Data lines change only while `sclk` is low, and they hold steady through each high phase and at its rising edge.
- R4: The first rising edge of `sclk` comes at least EN_SETUP_CYC cycles after the enable rises. `sclk` is high only while some enable is high.
- R5: An enable falls no sooner than CLK_HIGH_CYC+EN_HOLD_CYC cycles after the last rising edge of `sclk`.
- R6: Once an enable has fallen, no enable rises again for at least EN_GAP_CYC cycles.
- R7: With `mode_sel`=0, the word in `words_i[8i+7:8i]` goes to device i on `sdat`, framed by `sen_dev[i]`. Devices are served in ascending index order, at most one `sen_dev` bit is high at a time, and `sen_all` and `sdat_lane` stay low.
- R8: With `mode_sel`=1, one frame framed by `sen_all` carries word i on `sdat_lane[i]`. All devices update at the same `sen_all` falling edge, and `sen_dev` and `sdat` stay low.
- R9: The words and the mode are captured when a start is accepted. `start`, `words_i` and `mode_sel` have no effect while `busy` is high.
- R10: `busy` rises in the cycle after an accepted start and stays high through the final enable gap. `done` is a one-cycle pulse in the first cycle that `busy` is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a programming pass; accepted only when idle |
| mode_sel | input | 1 | 0 = per-device enables, 1 = common enable with per-device data |
| words_i | input | N_DEV*WORD_W | Word for device i in bits [WORD_W*i+WORD_W-1 : WORD_W*i] |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| sclk | output | 1 | Serial clock to all receivers |
| sdat | output | 1 | Shared data line (mode 0) |
| sen_dev | output | N_DEV | Per-device enables (mode 0) |
| sen_all | output | 1 | Common enable (mode 1) |
| sdat_lane | output | N_DEV | Per-device data lines (mode 1) |

## Verification
The bench models each receiver at the pins and measures every clock, setup, hold and gap interval. A design that shortened any phase by a single cycle would report a minimum below its parameter. Word patterns with all-zero, all-one and alternating bits expose a reversed bit order, a missing or extra shift, and a lane indexing mix-up, since each of these leaves a receiver with the wrong latched word. The bench drives a new start, new words and the other mode in the middle of a pass. A design that re-armed or re-captured would produce extra updates or wrong values. Order and simultaneity checks on the update times catch a design that serves devices out of sequence, or one that splits the common-enable frame.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HIGH,
    PH_LOW,
    PH_HOLD,
    PH_GAP
  } phase_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tsm_interval_timer.sv
module tsm_interval_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/tsm_lane_shifter.sv
module tsm_lane_shifter #(
  parameter int N_DEV  = 4,
  parameter int WORD_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    shift,
  input  logic [N_DEV*WORD_W-1:0] words,
  output logic [N_DEV-1:0]        msb
);

  for (genvar i = 0; i < N_DEV; i++) begin : g_lane
    logic [WORD_W-1:0] sh_q, sh_d;

    always_comb begin
      sh_d = sh_q;
      if (load)
        sh_d = words[i*WORD_W +: WORD_W];
      else if (shift)
        sh_d = {sh_q[WORD_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end

    assign msb[i] = sh_q[WORD_W-1];
  end

endmodule

// File: rtl/tsm_sequencer.sv
module tsm_sequencer
  import tsm_pkg::*;
#(
  parameter int N_DEV        = 4,
  parameter int WORD_W       = 8,
  parameter int CLK_HIGH_CYC = 3,
  parameter int CLK_LOW_CYC  = 3,
  parameter int EN_SETUP_CYC = 3,
  parameter int EN_HOLD_CYC  = 2,
  parameter int EN_GAP_CYC   = 5,
  localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int TMR_MAX = imax(imax(CLK_HIGH_CYC, CLK_LOW_CYC),
                                imax(imax(EN_SETUP_CYC, EN_HOLD_CYC), EN_GAP_CYC)),
  localparam int TMR_W = $clog2(TMR_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_sel,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_val,
  output logic             shf_load,
  output logic             shf_shift,
  output logic             capture,
  output phase_t           phase,
  output logic [IDX_W-1:0] dev_idx,
  output logic             mode_q,
  output logic             busy,
  output logic             done
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] LAST_DEV = IDX_W'(N_DEV - 1);

  phase_t           ph_q, ph_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [IDX_W-1:0] dev_q, dev_d;
  logic             mode_d;
  logic             done_q, done_d;

  always_comb begin
    ph_d      = ph_q;
    bit_d     = bit_q;
    dev_d     = dev_q;
    mode_d    = mode_q;
    done_d    = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    shf_load  = 1'b0;
    shf_shift = 1'b0;
    capture   = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          capture  = 1'b1;
          mode_d   = mode_sel;
          dev_d    = '0;
          bit_d    = '0;
          shf_load = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(EN_SETUP_CYC - 1);
          ph_d     = PH_SETUP;
        end
      end
      PH_SETUP: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(CLK_HIGH_CYC - 1);
          ph_d     = PH_HIGH;
        end
      end
      PH_HIGH: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          if (bit_q == LAST_BIT) begin
            tmr_val = TMR_W'(EN_HOLD_CYC - 1);
            ph_d    = PH_HOLD;
          end else begin
            tmr_val   = TMR_W'(CLK_LOW_CYC - 1);
            shf_shift = 1'b1;
            bit_d     = bit_q + 1'b1;
            ph_d      = PH_LOW;
          end
        end
      end
      PH_LOW: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(CLK_HIGH_CYC - 1);
          ph_d     = PH_HIGH;
        end
      end
      PH_HOLD: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(EN_GAP_CYC - 1);
          ph_d     = PH_GAP;
        end
      end
      PH_GAP: begin
        if (tmr_expired) begin
          if (!mode_q && (dev_q != LAST_DEV)) begin
            dev_d    = dev_q + 1'b1;
            bit_d    = '0;
            shf_load = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(EN_SETUP_CYC - 1);
            ph_d     = PH_SETUP;
          end else begin
            done_d = 1'b1;
            ph_d   = PH_IDLE;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      bit_q  <= '0;
      dev_q  <= '0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      dev_q  <= dev_d;
      mode_q <= mode_d;
      done_q <= done_d;
    end
  end

  assign phase   = ph_q;
  assign dev_idx = dev_q;
  assign busy    = (ph_q != PH_IDLE);
  assign done    = done_q;

endmodule

// File: rtl/tsm_pin_stage.sv
module tsm_pin_stage
  import tsm_pkg::*;
#(
  parameter int N_DEV = 4,
  localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_t           phase,
  input  logic [IDX_W-1:0] dev_idx,
  input  logic             mode_q,
  input  logic [N_DEV-1:0] lane_msb,
  output logic             sclk,
  output logic             sdat,
  output logic [N_DEV-1:0] sen_dev,
  output logic             sen_all,
  output logic [N_DEV-1:0] sdat_lane
);

  logic en_on;
  logic sclk_d, sdat_d, sen_all_d;
  logic [N_DEV-1:0] sen_dev_d, sdat_lane_d;

  assign en_on     = (phase == PH_SETUP) || (phase == PH_HIGH) ||
                     (phase == PH_LOW)   || (phase == PH_HOLD);
  assign sclk_d    = (phase == PH_HIGH);
  assign sen_all_d = en_on && mode_q;
  assign sdat_d    = en_on && !mode_q && lane_msb[dev_idx];

  for (genvar i = 0; i < N_DEV; i++) begin : g_dev
    assign sen_dev_d[i]   = en_on && !mode_q && (dev_idx == IDX_W'(i));
    assign sdat_lane_d[i] = en_on && mode_q && lane_msb[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk      <= 1'b0;
      sdat      <= 1'b0;
      sen_all   <= 1'b0;
      sen_dev   <= '0;
      sdat_lane <= '0;
    end else begin
      sclk      <= sclk_d;
      sdat      <= sdat_d;
      sen_all   <= sen_all_d;
      sen_dev   <= sen_dev_d;
      sdat_lane <= sdat_lane_d;
    end
  end

endmodule

// File: rtl/tsm_master.sv
module tsm_master
  import tsm_pkg::*;
#(
  parameter int N_DEV        = 4,
  parameter int WORD_W       = 8,
  parameter int CLK_HIGH_CYC = 3,
  parameter int CLK_LOW_CYC  = 3,
  parameter int EN_SETUP_CYC = 3,
  parameter int EN_HOLD_CYC  = 2,
  parameter int EN_GAP_CYC   = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    mode_sel,
  input  logic [N_DEV*WORD_W-1:0] words_i,
  output logic                    busy,
  output logic                    done,
  output logic                    sclk,
  output logic                    sdat,
  output logic [N_DEV-1:0]        sen_dev,
  output logic                    sen_all,
  output logic [N_DEV-1:0]        sdat_lane
);

  localparam int IDX_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1;
  localparam int TMR_MAX = imax(imax(CLK_HIGH_CYC, CLK_LOW_CYC),
                                imax(imax(EN_SETUP_CYC, EN_HOLD_CYC), EN_GAP_CYC));
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  logic                    tmr_load, tmr_expired;
  logic [TMR_W-1:0]        tmr_val;
  logic                    shf_load, shf_shift, capture;
  phase_t                  phase;
  logic [IDX_W-1:0]        dev_idx;
  logic                    mode_q;
  logic [N_DEV-1:0]        lane_msb;
  logic [N_DEV*WORD_W-1:0] words_q, words_d, shf_src;

  // Word hold register: written only when a start is accepted
  always_comb begin
    words_d = words_q;
    if (capture) words_d = words_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) words_q <= '0;
    else        words_q <= words_d;
  end

  assign shf_src = capture ? words_i : words_q;

  tsm_sequencer #(
    .N_DEV(N_DEV), .WORD_W(WORD_W),
    .CLK_HIGH_CYC(CLK_HIGH_CYC), .CLK_LOW_CYC(CLK_LOW_CYC),
    .EN_SETUP_CYC(EN_SETUP_CYC), .EN_HOLD_CYC(EN_HOLD_CYC),
    .EN_GAP_CYC(EN_GAP_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
    .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .shf_load(shf_load), .shf_shift(shf_shift), .capture(capture),
    .phase(phase), .dev_idx(dev_idx), .mode_q(mode_q),
    .busy(busy), .done(done)
  );

  tsm_interval_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  tsm_lane_shifter #(.N_DEV(N_DEV), .WORD_W(WORD_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .load(shf_load), .shift(shf_shift),
    .words(shf_src), .msb(lane_msb)
  );

  tsm_pin_stage #(.N_DEV(N_DEV)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase(phase), .dev_idx(dev_idx),
    .mode_q(mode_q), .lane_msb(lane_msb),
    .sclk(sclk), .sdat(sdat), .sen_dev(sen_dev), .sen_all(sen_all),
    .sdat_lane(sdat_lane)
  );

endmodule

// File: rtl/tsm_master_chk.sv
module tsm_master_chk #(
  parameter int N_DEV      = 4,
  parameter int EN_GAP_CYC = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             sclk,
  input logic             sdat,
  input logic [N_DEV-1:0] sen_dev,
  input logic             sen_all,
  input logic [N_DEV-1:0] sdat_lane
);

  localparam int GC_W = $clog2(EN_GAP_CYC + 2);

  logic            any_en, any_en_q, seen_fall;
  logic [GC_W-1:0] gap_cnt;

  assign any_en = (sen_dev != '0) || sen_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_en_q  <= 1'b0;
      seen_fall <= 1'b0;
      gap_cnt   <= '0;
    end else begin
      any_en_q <= any_en;
      if (any_en_q && !any_en) seen_fall <= 1'b1;
      if (any_en) gap_cnt <= '0;
      else if (gap_cnt != GC_W'(EN_GAP_CYC + 1)) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !sdat && sen_dev == '0 && !sen_all && sdat_lane == '0)); // R1
  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> ($stable(sdat) && $stable(sdat_lane))); // R3
  AST_CLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> any_en); // R4
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (any_en && !any_en_q && seen_fall) |-> (gap_cnt >= GC_W'(EN_GAP_CYC))); // R6
  AST_ONE_DEV_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sen_dev)); // R7
  AST_DEV_TOPO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sen_dev != '0) |-> (!sen_all && sdat_lane == '0)); // R7
  AST_COMMON_TOPO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    sen_all |-> (sen_dev == '0 && !sdat)); // R8
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R10
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R10

endmodule

bind tsm_master tsm_master_chk #(.N_DEV(N_DEV), .EN_GAP_CYC(EN_GAP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .sclk(sclk), .sdat(sdat), .sen_dev(sen_dev), .sen_all(sen_all),
  .sdat_lane(sdat_lane)
);

// File: tb/tsm_master_test.sv
module tsm_master_test;

  localparam int N  = 4;
  localparam int HI = 3;
  localparam int LO = 3;
  localparam int SU = 3;
  localparam int HO = 2;
  localparam int GP = 5;
  localparam int WD = 150000;
  localparam int NV = 6;

  // {mode_sel, words_i}; device i word in bits [8i+7:8i]
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 32'hA5_3C_0F_F0},
    {1'b1, 32'h81_7E_00_FF},
    {1'b0, 32'h00_00_00_00},
    {1'b1, 32'hFF_FF_FF_FF},
    {1'b0, 32'h12_34_56_78},
    {1'b1, 32'hC3_96_69_1E}
  };

  logic clk = 1'b0;
  logic rst_n, start, mode_sel;
  logic [31:0] words_i;
  logic busy, done, sclk, sdat, sen_all;
  logic [N-1:0] sen_dev, sdat_lane;

  always #4 clk = ~clk;

  tsm_master #(.N_DEV(N), .WORD_W(8), .CLK_HIGH_CYC(HI), .CLK_LOW_CYC(LO),
               .EN_SETUP_CYC(SU), .EN_HOLD_CYC(HO), .EN_GAP_CYC(GP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
    .words_i(words_i), .busy(busy), .done(done), .sclk(sclk), .sdat(sdat),
    .sen_dev(sen_dev), .sen_all(sen_all), .sdat_lane(sdat_lane)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  // Receiver models and interval monitor
  logic [7:0] rx_sh [N];
  logic [7:0] rx_lat [N];
  int rx_bits [N], rx_last [N], rx_upd [N], rx_time [N];
  logic [N-1:0] p_en_dev;
  logic p_sclk = 1'b0, p_en = 1'b0;
  int t_rise, t_fall, t_en_rise;
  bit first_pend = 0, had_fall = 0;
  int min_high = 1000, min_low = 1000, min_setup = 1000, min_hold = 1000, min_gap = 1000;
  bit dev_seen, lane_seen;

  initial begin
    for (int i = 0; i < N; i++) begin
      rx_sh[i] = '0; rx_lat[i] = '0; rx_bits[i] = 0; rx_last[i] = 0;
      rx_upd[i] = 0; rx_time[i] = 0;
    end
    p_en_dev = '0;
  end

  always @(negedge clk) begin
    logic any_en;
    cyc++;
    any_en = (sen_dev != '0) || sen_all;
    if ((sen_dev != '0) || sdat) dev_seen = 1;
    if (sen_all || (sdat_lane != '0)) lane_seen = 1;
    if (sclk && !p_sclk) begin
      if (first_pend) begin
        if (cyc - t_en_rise < min_setup) min_setup = cyc - t_en_rise;
        first_pend = 0;
      end else if (cyc - t_fall < min_low) min_low = cyc - t_fall;
      t_rise = cyc;
      for (int i = 0; i < N; i++)
        if (sen_dev[i] || sen_all) begin
          rx_sh[i] = {rx_sh[i][6:0], sdat | sdat_lane[i]};
          rx_bits[i]++;
        end
    end
    if (!sclk && p_sclk) begin
      if (cyc - t_rise < min_high) min_high = cyc - t_rise;
      t_fall = cyc;
    end
    if (any_en && !p_en) begin
      if (had_fall && (cyc - t_fall < min_gap)) min_gap = cyc - t_fall;
      t_en_rise = cyc;
      first_pend = 1;
    end
    if (!any_en && p_en) begin
      if (cyc - t_rise < min_hold) min_hold = cyc - t_rise;
      t_fall = cyc;
      had_fall = 1;
    end
    for (int i = 0; i < N; i++) begin
      if (!(sen_dev[i] || sen_all) && p_en_dev[i]) begin
        rx_lat[i] = rx_sh[i]; rx_upd[i]++; rx_time[i] = cyc;
        rx_last[i] = rx_bits[i]; rx_bits[i] = 0;
      end
      p_en_dev[i] = sen_dev[i] || sen_all;
    end
    p_sclk = sclk;
    p_en = any_en;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic run_xfer(input logic m, input logic [31:0] w, input bit disturb);
    int base [N];
    int n;
    for (int i = 0; i < N; i++) base[i] = rx_upd[i];
    dev_seen = 0; lane_seen = 0;
    mode_sel = m; words_i = w; start = 1'b1;
    tick();
    start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after accepted start", busy, 1);
    if (disturb) begin
      repeat (15) tick();
      start = 1'b1; mode_sel = ~m; words_i = ~w;
      tick();
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin tick(); n++; end
    chk(done == 1'b1, "R10", "done pulse seen", done, 1);
    chk(busy == 1'b0, "R10", "busy low with done", busy, 0);
    tick();
    chk(done == 1'b0, "R10", "done lasts one cycle", done, 0);
    for (int i = 0; i < N; i++) begin
      chk(rx_lat[i] == w[i*8 +: 8], m ? "R8" : "R7", "latched word", rx_lat[i], w[i*8 +: 8]);
      chk(rx_upd[i] == base[i] + 1, "R9", "one update per device", rx_upd[i] - base[i], 1);
      chk(rx_last[i] == 8, "R3", "bits per enable window", rx_last[i], 8);
    end
    for (int i = 1; i < N; i++) begin
      if (m) chk(rx_time[i] == rx_time[0], "R8", "simultaneous update",
                 rx_time[i] - rx_time[0], 0);
      else   chk(rx_time[i] > rx_time[i-1], "R7", "ascending update order",
                 rx_time[i] - rx_time[i-1], 1);
    end
    if (m) chk(!dev_seen, "R8", "per-device enable/shared data quiet", dev_seen, 0);
    else   chk(!lane_seen, "R7", "common enable/lane data quiet", lane_seen, 0);
    if (disturb) begin
      repeat (100) tick();
      chk(rx_upd[0] == base[0] + 1 && !busy, "R9", "start while busy ignored",
          rx_upd[0] - base[0], 1);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mode_sel = 1'b0; words_i = '0;
    repeat (3) tick();
    chk(!sclk && !sdat && sen_dev == '0 && !sen_all && sdat_lane == '0, "R1",
        "pins low in reset", {sclk, sdat, sen_all}, 0);
    rst_n = 1'b1;
    tick();
    chk(!busy && !done, "R1", "busy/done low after reset", {busy, done}, 0);

    for (int v = 0; v < NV; v++) run_xfer(VEC[v][32], VEC[v][31:0], 1'b0);
    run_xfer(1'b0, 32'h5A_C1_E7_09, 1'b1);
    run_xfer(1'b1, 32'h0F_F0_33_CC, 1'b1);

    chk(min_high >= HI, "R2", "min sclk high", min_high, HI);
    chk(min_low >= LO, "R2", "min sclk low", min_low, LO);
    chk(min_setup >= SU, "R4", "min enable-to-first-rise", min_setup, SU);
    chk(min_hold >= HI + HO, "R5", "min last-rise-to-enable-fall", min_hold, HI + HO);
    chk(min_gap >= GP, "R6", "min enable gap", min_gap, GP);

    // Reset in the middle of a pass drops every pin at once
    mode_sel = 1'b1; words_i = 32'hFFFF_FFFF; start = 1'b1;
    tick();
    start = 1'b0;
    repeat (20) tick();
    rst_n = 1'b0;
    #1;
    chk(!sclk && !sdat && sen_dev == '0 && !sen_all && sdat_lane == '0 && !busy,
        "R1", "pins low on mid-pass reset", {sclk, sen_all, busy}, 0);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > WD);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WD);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule